// File: doc/BRIEF.md
# DES Block Decryption Engine

This block decrypts 64-bit data blocks with single DES under one 64-bit key. A key is presented on a load strobe. The eight key bytes are put in reverse order, and the sixteen 48-bit round subkeys are then computed into a register store, one per clock. After that, blocks enter through a valid/ready handshake. Each block takes one capture cycle, sixteen Feistel rounds at one round per clock, and one output-register cycle. The result appears with a single-cycle valid strobe.

Only one block is in flight at a time. The input stays closed while the key schedule runs, and it reopens in the same cycle that a result is presented. A mode input, sampled when a block is accepted, can turn the same datapath into an encryptor so that test software can build known-answer and round-trip checks. A parameter can remove this option.

Top module: `des_block_decrypt`

## Requirements
- R1: After reset, in_ready, out_valid and out_block are all 0. No block is accepted before the first key load has finished.
- R2: A key_load edge starts the key schedule. in_ready is low for the 16 clock edges after the load edge and rises after the 16th. A load during a running schedule restarts it with the new key, and all subkeys are recomputed.
- R3: With mode_encrypt low at acceptance, out_block is the standard DES decryption of in_block. DES bit 1 is bit 63, bits 63..32 form the left half and bits 31..0 form the right half. Subkeys are applied from the sixteenth down to the first.
- R4: The DES key is key_in with its bytes reversed: key_in[7:0] becomes the most significant key byte and key_in[63:56] becomes the least significant.
- R5: out_valid is high in the cycle that follows the 17th rising edge after the accepting edge. The accepting edge captures the block, the next 16 edges run the rounds, and the 17th edge registers the result.
- R6: With mode_encrypt high at acceptance, out_block is the DES encryption of in_block. mode_encrypt has no effect at any other time.
- R7: A key_load pulse while a block is in flight is ignored. The block completes under the old key, the key schedule does not start, and later blocks still use the old key.
- R8: in_ready is low from the accepting edge until the cycle in which out_valid is high. In that cycle in_ready is high again if a key is ready.
- R9: out_valid lasts exactly one cycle, and out_block holds its value until the next result is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Strobe: take key_in and start the key schedule |
| key_in | input | 64 | Key in board byte order (bytes reversed before use) |
| mode_encrypt | input | 1 | 1 = encrypt the accepted block, 0 = decrypt |
| in_valid | input | 1 | Block input valid |
| in_ready | output | 1 | Engine can accept a block |
| in_block | input | 64 | Input block |
| out_valid | output | 1 | One-cycle result strobe |
| out_block | output | 64 | Result block, held until the next result |

## Verification
The bench builds the engine with its defaults: key byte reversal on and the encrypt option present. The encrypt option makes it possible to check round trips through both directions and to check the encryption known-answer vector on the same hardware. Known-answer keys go in byte-reversed, so R4 is checked both by exact matches and by a deliberate mismatch with an unreversed key. Extra vectors come from the complementation property and from published DES pairs. Schedule restarts and key loads during a block in flight test the sequencing around the subkey store.

// File: rtl/des_pkg.sv
package des_pkg;

   localparam int unsigned DES_BLOCK = 64;
   localparam int unsigned DES_KEY   = 64;
   localparam int unsigned DES_HALF  = 32;
   localparam int unsigned DES_CD    = 28;
   localparam int unsigned DES_SUB   = 48;
   localparam int unsigned DES_ROUND = 16;

   localparam logic [6:0] IP_T [64] = '{
      58, 50, 42, 34, 26, 18, 10,  2, 60, 52, 44, 36, 28, 20, 12,  4,
      62, 54, 46, 38, 30, 22, 14,  6, 64, 56, 48, 40, 32, 24, 16,  8,
      57, 49, 41, 33, 25, 17,  9,  1, 59, 51, 43, 35, 27, 19, 11,  3,
      61, 53, 45, 37, 29, 21, 13,  5, 63, 55, 47, 39, 31, 23, 15,  7};

   localparam logic [6:0] FP_T [64] = '{
      40,  8, 48, 16, 56, 24, 64, 32, 39,  7, 47, 15, 55, 23, 63, 31,
      38,  6, 46, 14, 54, 22, 62, 30, 37,  5, 45, 13, 53, 21, 61, 29,
      36,  4, 44, 12, 52, 20, 60, 28, 35,  3, 43, 11, 51, 19, 59, 27,
      34,  2, 42, 10, 50, 18, 58, 26, 33,  1, 41,  9, 49, 17, 57, 25};

   localparam logic [5:0] E_T [48] = '{
      32,  1,  2,  3,  4,  5,  4,  5,  6,  7,  8,  9,
       8,  9, 10, 11, 12, 13, 12, 13, 14, 15, 16, 17,
      16, 17, 18, 19, 20, 21, 20, 21, 22, 23, 24, 25,
      24, 25, 26, 27, 28, 29, 28, 29, 30, 31, 32,  1};

   localparam logic [5:0] P_T [32] = '{
      16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
       2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25};

   localparam logic [6:0] PC1_T [56] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

   localparam logic [5:0] PC2_T [48] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

   localparam logic [3:0] SB1 [64] = '{
      14,  4, 13,  1,  2, 15, 11,  8,  3, 10,  6, 12,  5,  9,  0,  7,
       0, 15,  7,  4, 14,  2, 13,  1, 10,  6, 12, 11,  9,  5,  3,  8,
       4,  1, 14,  8, 13,  6,  2, 11, 15, 12,  9,  7,  3, 10,  5,  0,
      15, 12,  8,  2,  4,  9,  1,  7,  5, 11,  3, 14, 10,  0,  6, 13};
   localparam logic [3:0] SB2 [64] = '{
      15,  1,  8, 14,  6, 11,  3,  4,  9,  7,  2, 13, 12,  0,  5, 10,
       3, 13,  4,  7, 15,  2,  8, 14, 12,  0,  1, 10,  6,  9, 11,  5,
       0, 14,  7, 11, 10,  4, 13,  1,  5,  8, 12,  6,  9,  3,  2, 15,
      13,  8, 10,  1,  3, 15,  4,  2, 11,  6,  7, 12,  0,  5, 14,  9};
   localparam logic [3:0] SB3 [64] = '{
      10,  0,  9, 14,  6,  3, 15,  5,  1, 13, 12,  7, 11,  4,  2,  8,
      13,  7,  0,  9,  3,  4,  6, 10,  2,  8,  5, 14, 12, 11, 15,  1,
      13,  6,  4,  9,  8, 15,  3,  0, 11,  1,  2, 12,  5, 10, 14,  7,
       1, 10, 13,  0,  6,  9,  8,  7,  4, 15, 14,  3, 11,  5,  2, 12};
   localparam logic [3:0] SB4 [64] = '{
       7, 13, 14,  3,  0,  6,  9, 10,  1,  2,  8,  5, 11, 12,  4, 15,
      13,  8, 11,  5,  6, 15,  0,  3,  4,  7,  2, 12,  1, 10, 14,  9,
      10,  6,  9,  0, 12, 11,  7, 13, 15,  1,  3, 14,  5,  2,  8,  4,
       3, 15,  0,  6, 10,  1, 13,  8,  9,  4,  5, 11, 12,  7,  2, 14};
   localparam logic [3:0] SB5 [64] = '{
       2, 12,  4,  1,  7, 10, 11,  6,  8,  5,  3, 15, 13,  0, 14,  9,
      14, 11,  2, 12,  4,  7, 13,  1,  5,  0, 15, 10,  3,  9,  8,  6,
       4,  2,  1, 11, 10, 13,  7,  8, 15,  9, 12,  5,  6,  3,  0, 14,
      11,  8, 12,  7,  1, 14,  2, 13,  6, 15,  0,  9, 10,  4,  5,  3};
   localparam logic [3:0] SB6 [64] = '{
      12,  1, 10, 15,  9,  2,  6,  8,  0, 13,  3,  4, 14,  7,  5, 11,
      10, 15,  4,  2,  7, 12,  9,  5,  6,  1, 13, 14,  0, 11,  3,  8,
       9, 14, 15,  5,  2,  8, 12,  3,  7,  0,  4, 10,  1, 13, 11,  6,
       4,  3,  2, 12,  9,  5, 15, 10, 11, 14,  1,  7,  6,  0,  8, 13};
   localparam logic [3:0] SB7 [64] = '{
       4, 11,  2, 14, 15,  0,  8, 13,  3, 12,  9,  7,  5, 10,  6,  1,
      13,  0, 11,  7,  4,  9,  1, 10, 14,  3,  5, 12,  2, 15,  8,  6,
       1,  4, 11, 13, 12,  3,  7, 14, 10, 15,  6,  8,  0,  5,  9,  2,
       6, 11, 13,  8,  1,  4, 10,  7,  9,  5,  0, 15, 14,  2,  3, 12};
   localparam logic [3:0] SB8 [64] = '{
      13,  2,  8,  4,  6, 15, 11,  1, 10,  9,  3, 14,  5,  0, 12,  7,
       1, 15, 13,  8, 10,  3,  7,  4, 12,  5,  6, 11,  0, 14,  9,  2,
       7, 11,  4,  1,  9, 12, 14,  2,  0,  6, 10, 13, 15,  3,  5,  8,
       2,  1, 14,  7,  4, 10,  8, 13, 15, 12,  9,  0,  3,  5,  6, 11};

   // Bit positions count from 1 at the most significant bit.
   function automatic logic [63:0] perm_initial(input logic [63:0] x);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[63-i] = x[64-int'(IP_T[i])];
      return r;
   endfunction

   function automatic logic [63:0] perm_final(input logic [63:0] x);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[63-i] = x[64-int'(FP_T[i])];
      return r;
   endfunction

   function automatic logic [47:0] expand(input logic [31:0] x);
      logic [47:0] r;
      for (int i = 0; i < 48; i++) r[47-i] = x[32-int'(E_T[i])];
      return r;
   endfunction

   function automatic logic [31:0] perm_p(input logic [31:0] x);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[31-i] = x[32-int'(P_T[i])];
      return r;
   endfunction

   function automatic logic [55:0] choice1(input logic [63:0] k);
      logic [55:0] r;
      for (int i = 0; i < 56; i++) r[55-i] = k[64-int'(PC1_T[i])];
      return r;
   endfunction

   function automatic logic [47:0] choice2(input logic [55:0] cd);
      logic [47:0] r;
      for (int i = 0; i < 48; i++) r[47-i] = cd[56-int'(PC2_T[i])];
      return r;
   endfunction

   function automatic logic [3:0] sbox(input int n, input logic [5:0] x);
      logic [5:0] idx;
      idx = {x[5], x[0], x[4:1]};
      case (n)
         0: return SB1[idx];
         1: return SB2[idx];
         2: return SB3[idx];
         3: return SB4[idx];
         4: return SB5[idx];
         5: return SB6[idx];
         6: return SB7[idx];
         default: return SB8[idx];
      endcase
   endfunction

   // Schedule steps 0, 1, 8 and 15 rotate by one place, all others by two.
   function automatic logic single_step(input int step);
      return (step == 0) || (step == 1) || (step == 8) || (step == 15);
   endfunction

   function automatic logic [27:0] rotl28(input logic [27:0] x, input logic one);
      return one ? {x[26:0], x[27]} : {x[25:0], x[27:26]};
   endfunction

endpackage

// File: rtl/des_key_schedule.sv
module des_key_schedule #(
   parameter int unsigned ROUNDS           = 16,
   parameter bit          KEY_BYTE_REVERSE = 1'b1,
   localparam int unsigned CW              = $clog2(ROUNDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [63:0]              key,
   output logic                     busy,
   output logic                     ready,
   output logic [ROUNDS-1:0][47:0]  subkeys
);
   import des_pkg::*;

   logic [63:0]   key_eff;
   logic [27:0]   c_q, d_q, c_nx, d_nx;
   logic [CW-1:0] cnt_q;
   logic          busy_q, ready_q;

   generate
      if (KEY_BYTE_REVERSE) begin : g_swap
         for (genvar b = 0; b < 8; b++) begin : g_byte
            assign key_eff[8*b +: 8] = key[8*(7-b) +: 8];
         end
      end else begin : g_direct
         assign key_eff = key;
      end
   endgenerate

   always_comb begin
      c_nx = rotl28(c_q, single_step(int'(cnt_q)));
      d_nx = rotl28(d_q, single_step(int'(cnt_q)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q     <= '0;
         d_q     <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         ready_q <= 1'b0;
         subkeys <= '0;
      end else if (load) begin
         {c_q, d_q} <= choice1(key_eff);
         cnt_q      <= '0;
         busy_q     <= 1'b1;
         ready_q    <= 1'b0;
      end else if (busy_q) begin
         c_q            <= c_nx;
         d_q            <= d_nx;
         subkeys[cnt_q] <= choice2({c_nx, d_nx});
         cnt_q          <= cnt_q + 1'b1;
         if (cnt_q == CW'(ROUNDS-1)) begin
            busy_q  <= 1'b0;
            ready_q <= 1'b1;
         end
      end
   end

   assign busy  = busy_q;
   assign ready = ready_q;

   // R2: the key store is never marked ready while a schedule runs.
   a_r2_ready_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ready);
   // R2: a load always leaves the schedule running on the next cycle.
   a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

endmodule

// File: rtl/des_feistel.sv
module des_feistel (
   input  logic [31:0] half,
   input  logic [47:0] subkey,
   output logic [31:0] mix
);
   import des_pkg::*;

   logic [47:0] e_x;
   logic [31:0] s_out;

   assign e_x = expand(half) ^ subkey;

   generate
      for (genvar b = 0; b < 8; b++) begin : g_box
         assign s_out[31-4*b -: 4] = sbox(b, e_x[47-6*b -: 6]);
      end
   endgenerate

   assign mix = perm_p(s_out);

endmodule

// File: rtl/des_round_engine.sv
module des_round_engine #(
   parameter int unsigned ROUNDS        = 16,
   parameter bit          ALLOW_ENCRYPT = 1'b1,
   localparam int unsigned RW           = $clog2(ROUNDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     key_ok,
   input  logic [ROUNDS-1:0][47:0]  subkeys,
   input  logic                     mode_encrypt,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [63:0]              in_block,
   output logic                     out_valid,
   output logic [63:0]              out_block,
   output logic                     in_flight
);
   import des_pkg::*;

   logic [31:0]   l_q, r_q, f_out;
   logic [63:0]   ip_x;
   logic [RW-1:0] rnd_q, sk_idx;
   logic          run_q, fin_q, enc_q, enc_in, accept;

   generate
      if (ALLOW_ENCRYPT) begin : g_enc
         assign enc_in = mode_encrypt;
      end else begin : g_dec_only
         assign enc_in = mode_encrypt & 1'b0;
      end
   endgenerate

   assign in_ready  = key_ok && !run_q && !fin_q;
   assign accept    = in_valid && in_ready;
   assign in_flight = run_q || fin_q;
   assign ip_x      = perm_initial(in_block);
   assign sk_idx    = enc_q ? rnd_q : (RW'(ROUNDS-1) - rnd_q);

   des_feistel u_feistel (
      .half   (r_q),
      .subkey (subkeys[sk_idx]),
      .mix    (f_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_q       <= '0;
         r_q       <= '0;
         rnd_q     <= '0;
         run_q     <= 1'b0;
         fin_q     <= 1'b0;
         enc_q     <= 1'b0;
         out_valid <= 1'b0;
         out_block <= '0;
      end else begin
         out_valid <= 1'b0;
         if (accept) begin
            l_q   <= ip_x[63:32];
            r_q   <= ip_x[31:0];
            rnd_q <= '0;
            enc_q <= enc_in;
            run_q <= 1'b1;
         end else if (run_q) begin
            l_q   <= r_q;
            r_q   <= l_q ^ f_out;
            rnd_q <= rnd_q + 1'b1;
            if (rnd_q == RW'(ROUNDS-1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end
         end else if (fin_q) begin
            out_block <= perm_final({r_q, l_q});
            out_valid <= 1'b1;
            fin_q     <= 1'b0;
         end
      end
   end

   // R8: a single block at a time.
   a_r8_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
   // R5: the result follows one cycle after the last round.
   a_r5_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && rnd_q == RW'(ROUNDS-1)) |=> !out_valid ##1 out_valid);
   // R9: single-cycle strobe.
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R9: result held between strobes.
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_block));

endmodule

// File: rtl/des_block_decrypt.sv
module des_block_decrypt #(
   parameter int unsigned BLOCK_BITS       = 64,
   parameter int unsigned KEY_BITS         = 64,
   parameter int unsigned ROUNDS           = 16,
   parameter bit          KEY_BYTE_REVERSE = 1'b1,
   parameter bit          ALLOW_ENCRYPT    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  key_load,
   input  logic [KEY_BITS-1:0]   key_in,
   input  logic                  mode_encrypt,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [BLOCK_BITS-1:0] in_block,
   output logic                  out_valid,
   output logic [BLOCK_BITS-1:0] out_block
);
   generate
      if (BLOCK_BITS != des_pkg::DES_BLOCK) begin : g_bad_block
         $error("des_block_decrypt: BLOCK_BITS must be 64");
      end
      if (KEY_BITS != des_pkg::DES_KEY) begin : g_bad_key
         $error("des_block_decrypt: KEY_BITS must be 64");
      end
      if (ROUNDS != des_pkg::DES_ROUND) begin : g_bad_rounds
         $error("des_block_decrypt: ROUNDS must be 16");
      end
   endgenerate

   logic                    key_busy, key_ready, sched_load, in_flight;
   logic [ROUNDS-1:0][47:0] subkeys;

   // A key arriving while a block is in flight is dropped.
   assign sched_load = key_load && !in_flight;

   des_key_schedule #(
      .ROUNDS           (ROUNDS),
      .KEY_BYTE_REVERSE (KEY_BYTE_REVERSE)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sched_load),
      .key     (key_in),
      .busy    (key_busy),
      .ready   (key_ready),
      .subkeys (subkeys)
   );

   des_round_engine #(
      .ROUNDS        (ROUNDS),
      .ALLOW_ENCRYPT (ALLOW_ENCRYPT)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_ok       (key_ready && !key_busy),
      .subkeys      (subkeys),
      .mode_encrypt (mode_encrypt),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_block     (in_block),
      .out_valid    (out_valid),
      .out_block    (out_block),
      .in_flight    (in_flight)
   );

   // R2: input closed while subkeys are being computed.
   a_r2_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      key_busy |-> !in_ready);
   // R7: a key load during a block does not start the schedule.
   a_r7_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (key_load && in_flight) |=> !key_busy);

endmodule

// File: tb/des_block_decrypt_tb_top.sv
`timescale 1ns/100ps
module des_block_decrypt_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_load = 1'b0;
   logic [63:0] key_in = '0;
   logic        mode_encrypt = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_block = '0;
   logic        out_valid;
   logic [63:0] out_block;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [63:0] exp_q[$];
   int          kind_q[$];   // 0 capture only, 1 must equal, 2 must differ
   int          acc_q[$];
   string       req_q[$];
   logic [63:0] last_out = '0;
   logic        prev_valid = 1'b0;
   logic [63:0] prev_data = '0;

   des_block_decrypt dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_load     (key_load),
      .key_in       (key_in),
      .mode_encrypt (mode_encrypt),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_block     (in_block),
      .out_valid    (out_valid),
      .out_block    (out_block)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Monitor: pops expectations as results appear.
   always @(negedge clk) begin
      if (prev_valid) begin
         chk(!out_valid, "R9 strobe width", {63'd0, out_valid}, 64'd0);
         chk(out_block == prev_data, "R9 hold", out_block, prev_data);
      end
      if (out_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected result", out_block, 64'd0);
         end else begin
            logic [63:0] e;
            int k, a;
            string r;
            e = exp_q.pop_front();
            k = kind_q.pop_front();
            a = acc_q.pop_front();
            r = req_q.pop_front();
            chk(cyc == a + 17, "R5 latency", 64'(cyc), 64'(a + 17));
            chk(in_ready == 1'b1, "R8 reopen with result", {63'd0, in_ready}, 64'd1);
            if (k == 1) chk(out_block == e, r, out_block, e);
            if (k == 2) chk(out_block != e, r, out_block, e);
            last_out = out_block;
         end
      end
      prev_valid = out_valid;
      prev_data  = out_block;
   end

   function automatic logic [63:0] brev(input logic [63:0] k);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = k[8*(7-b) +: 8];
      return r;
   endfunction

   task automatic pulse_key(input logic [63:0] k);
      key_in = k;
      key_load = 1'b1;
      @(negedge clk);
      key_load = 1'b0;
   endtask

   // R2: schedule window timing after the load edge.
   task automatic load_key(input logic [63:0] k);
      pulse_key(k);
      repeat (15) @(negedge clk);
      chk(in_ready == 1'b0, "R2 closed during schedule", {63'd0, in_ready}, 64'd0);
      @(negedge clk);
      chk(in_ready == 1'b1, "R2 open after schedule", {63'd0, in_ready}, 64'd1);
   endtask

   task automatic send(input logic [63:0] d, input bit enc, input int kind,
                       input logic [63:0] e, input string req);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_block = d;
      mode_encrypt = enc;
      exp_q.push_back(e);
      kind_q.push_back(kind);
      acc_q.push_back(cyc + 1);
      req_q.push_back(req);
      @(negedge clk);
      in_valid = 1'b0;
      mode_encrypt = ~enc;   // R6: changes after acceptance have no effect
      in_block = ~d;
      chk(in_ready == 1'b0, "R8 closed in flight", {63'd0, in_ready}, 64'd0);
   endtask

   task automatic drain;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   localparam logic [63:0] KA = 64'h133457799BBCDFF1;
   localparam logic [63:0] PA = 64'h0123456789ABCDEF;
   localparam logic [63:0] CA = 64'h85E813540F0AB405;

   initial begin
      logic [63:0] y;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(in_ready == 1'b0, "R1 in_ready", {63'd0, in_ready}, 64'd0);
      chk(out_valid == 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
      chk(out_block == 64'd0, "R1 out_block", out_block, 64'd0);
      // R1: no acceptance without a key
      in_valid = 1'b1;
      in_block = CA;
      repeat (4) @(negedge clk);
      chk(in_ready == 1'b0, "R1 no key no accept", {63'd0, in_ready}, 64'd0);
      in_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(out_valid == 1'b0, "R1 no result", {63'd0, out_valid}, 64'd0);

      // R2: restart mid-schedule, then the second key governs
      pulse_key(64'd0);
      repeat (5) @(negedge clk);
      load_key(brev(KA));
      // R3 / R4: decryption known answer with byte-reversed key
      send(CA, 1'b0, 1, PA, "R3 R4 decrypt known answer");
      drain();
      // R6: encryption known answer
      send(PA, 1'b1, 1, CA, "R6 encrypt known answer");
      drain();
      // R6 / R3: round trip
      send(64'hDEADBEEF01234567, 1'b1, 0, 64'd0, "R6 capture");
      drain();
      y = last_out;
      send(y, 1'b0, 1, 64'hDEADBEEF01234567, "R3 R6 round trip");
      drain();
      // R8: back-to-back blocks
      send(CA, 1'b0, 1, PA, "R8 first of pair");
      send(PA, 1'b1, 1, CA, "R8 second of pair");
      drain();
      // R7: key load in flight ignored
      send(CA, 1'b0, 1, PA, "R7 block during load");
      repeat (3) @(negedge clk);
      pulse_key(64'hFFFF0000FFFF0000);
      drain();
      chk(in_ready == 1'b1, "R7 schedule not started", {63'd0, in_ready}, 64'd1);
      send(CA, 1'b0, 1, PA, "R7 old key retained");
      drain();
      // R3: complementation property vector
      load_key(brev(~KA));
      send(~CA, 1'b0, 1, ~PA, "R3 complement vector");
      drain();
      // R3: published pair
      load_key(brev(64'h0E329232EA6D0D73));
      send(64'h0000000000000000, 1'b0, 1, 64'h8787878787878787, "R3 second key");
      drain();
      // R3: all-zero key
      load_key(64'd0);
      send(64'h8CA64DE9C1B123A7, 1'b0, 1, 64'd0, "R3 zero key");
      drain();
      // R4: an unreversed key must not give the known answer
      load_key(KA);
      send(CA, 1'b0, 2, PA, "R4 unreversed key differs");
      drain();

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule